// File: doc/BRIEF.md
# Per-Core Clock Ratio Controller

This block takes one parent clock and produces a clock-enable pulse train for each of up to four cores. Each core runs at its own integer ratio of the parent rate. Software reaches the block through a small register port. It places a new ratio for every core in one shared ratio register. It then picks the cores that should take the new value and raises a global trigger. The selected cores load the staged value only when their own divide counter wraps, so no pulse arrives early and no pulse is cut short.

The ratio register holds one field per core. Writing it has no direct effect on the running outputs. Software may clear the core selections and the trigger afterwards without changing any running ratio.

Top module: `coreclk_ratio_ctrl`

## Requirements
- R1: After reset, both the control register (offset 0x0) and the ratio register (offset 0xC) read 0, and every core output is high on every parent cycle (ratio 1).
- R2: The ratio register at offset 0xC reads back the full 32-bit value last written to it. Core i's 6-bit ratio field sits at bits [8*i+5 : 8*i].
- R3: The control register at offset 0x0 reads back the full 32-bit value last written to it.
- R4: Writing the ratio register alone never changes any core's output period.
- R5: Bit 20+i of the control register selects core i. When bit 24 rises from 0 to 1, every selected core takes its staged field, and unselected cores keep their current period.
- R6: The trigger acts on its rising edge only. Rewriting bit 24 as 1 while it is already 1 applies nothing.
- R7: Clearing the selection bits and the trigger bit leaves every core's period unchanged.
- R8: A staged field of 0 gives a period of 1. A staged field above 3 gives a period of 3.
- R9: Each core output is a one-cycle pulse that repeats exactly every N parent cycles, where N (1 to 3) is that core's active ratio.
- R10: A new ratio takes effect only at a wrap of that core's counter. Every gap between pulses across a switch equals either the old ratio or the new ratio.
- R11: A read from any offset other than 0x0 and 0xC returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| core_tick | output | 4 | Per-core clock-enable pulses |

## Verification
The in-RTL properties check, on every cycle, the following:
- each active ratio stays within 1 to 3;
- an active ratio changes only on a counter wrap;
- no core goes longer than its largest allowed period without a pulse;
- a detected trigger edge lasts a single cycle;
- a ratio write lands in the register.

Several behaviours depend on what software did earlier, so only the directed scenarios can show them:
- which cores a trigger selects;
- that a trigger held high does not apply a second time;
- that clearing the control bits leaves every core undisturbed;
- that ratios saturate;
- that pulse gaps across a switch are clean.

// File: rtl/coreclk_pkg.sv
package coreclk_pkg;
  localparam int RATIO_W      = 6;
  localparam int FIELD_STRIDE = 8;
  localparam int SEL_BASE     = 20;
  localparam int TRIG_BIT     = 24;
  localparam int MAX_RATIO    = 3;
  localparam logic [3:0] CTRL_ADDR  = 4'h0;
  localparam logic [3:0] RATIO_ADDR = 4'hC;

  // Clamp a staged field to the legal ratio range.
  function automatic logic [RATIO_W-1:0] sat_ratio(input logic [RATIO_W-1:0] r);
    if (r == '0) return RATIO_W'(1);
    if (r > RATIO_W'(MAX_RATIO)) return RATIO_W'(MAX_RATIO);
    return r;
  endfunction
endpackage

// File: rtl/coreclk_regs.sv
module coreclk_regs
  import coreclk_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] ratio_q,
  output logic              trig_rise
);
  logic trig_q;
  logic hit_ctrl, hit_ratio;

  assign hit_ctrl  = (addr == ADDR_W'(CTRL_ADDR));
  assign hit_ratio = (addr == ADDR_W'(RATIO_ADDR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ratio_q <= '0;
      trig_q  <= 1'b0;
    end else begin
      trig_q <= ctrl_q[TRIG_BIT];
      if (wr_en && hit_ctrl)  ctrl_q  <= wdata;
      if (wr_en && hit_ratio) ratio_q <= wdata;
    end
  end

  assign trig_rise = ctrl_q[TRIG_BIT] & ~trig_q;

  always_comb begin
    rdata = '0;
    if (hit_ctrl)       rdata = ctrl_q;
    else if (hit_ratio) rdata = ratio_q;
  end

  // R6
  trig_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rise |=> !trig_rise);
  // R2
  ratio_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_ratio) |=> (ratio_q == $past(wdata)));
endmodule

// File: rtl/coreclk_lane.sv
module coreclk_lane
  import coreclk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [RATIO_W-1:0] staged_i,
  output logic               tick_o
);
  logic [RATIO_W-1:0] active_q, pend_q, cnt_q;
  logic               pend_v_q;
  logic               wrap;
  logic [1:0]         gap_q;

  assign wrap   = (cnt_q == active_q - RATIO_W'(1));
  assign tick_o = wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= RATIO_W'(1);
      pend_q   <= RATIO_W'(1);
      pend_v_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + RATIO_W'(1);
      if (wrap && pend_v_q) active_q <= pend_q;
      if (load_i) begin
        pend_q   <= sat_ratio(staged_i);
        pend_v_q <= 1'b1;
      end else if (wrap) begin
        pend_v_q <= 1'b0;
      end
    end
  end

  // Gap tracker used only by the properties below.
  always_ff @(posedge clk) begin
    if (!rst_n)      gap_q <= '0;
    else if (wrap)   gap_q <= '0;
    else if (gap_q != 2'd3) gap_q <= gap_q + 2'd1;
  end

  // R8
  ratio_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q >= RATIO_W'(1)) && (active_q <= RATIO_W'(MAX_RATIO)));
  // R10
  switch_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(active_q));
  // R9
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q < 2'(MAX_RATIO));
endmodule

// File: rtl/coreclk_ratio_ctrl.sv
module coreclk_ratio_ctrl
  import coreclk_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_CORES-1:0] core_tick
);
  logic [DATA_W-1:0]    ctrl_q, ratio_q;
  logic                 trig_rise;
  logic [NUM_CORES-1:0] load_vec;

  coreclk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ctrl_q(ctrl_q),
    .ratio_q(ratio_q), .trig_rise(trig_rise)
  );

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    logic [RATIO_W-1:0] staged;
    assign staged      = ratio_q[i*FIELD_STRIDE +: RATIO_W];
    assign load_vec[i] = trig_rise & ctrl_q[SEL_BASE + i];

    coreclk_lane u_lane (
      .clk(clk), .rst_n(rst_n), .load_i(load_vec[i]),
      .staged_i(staged), .tick_o(core_tick[i])
    );
  end

  // R5
  load_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(load_vec) > 0 |-> $countones(ctrl_q[SEL_BASE +: NUM_CORES]) > 0);
endmodule

// File: tb/sim_coreclk_ratio_ctrl.sv
`timescale 1ns/1ps
module sim_coreclk_ratio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  core_tick;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  coreclk_ratio_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_tick(core_tick)
  );

  function automatic int exp_ratio(input int f);
    if (f == 0) return 1;
    if (f > 3) return 3;
    return f;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic period(input int c, output int p);
    int n = 0;
    for (int k = 0; k < 10 && !core_tick[c]; k++) @(negedge clk);
    p = 0;
    do begin
      @(negedge clk); n++;
    end while (!core_tick[c] && n < 10);
    p = n;
  endtask

  task automatic expect_periods(input int e0, e1, e2, e3, input string req);
    int exp[4];
    int p;
    exp[0] = e0; exp[1] = e1; exp[2] = e2; exp[3] = e3;
    for (int c = 0; c < 4; c++) begin
      period(c, p);
      chk(p == exp[c], req, p, exp[c]);
    end
  endtask

  task automatic apply(input logic [3:0] sel);
    wr(4'h0, (32'(sel) << 20) | (32'h1 << 24));
    wr(4'h0, 32'h0);
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(4'h0, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(4'hC, d); chk(d == 0, "R1 ratio", d, 0);
    expect_periods(1, 1, 1, 1, "R1 R9 reset period");
  endtask

  task automatic t_readback;
    logic [31:0] d;
    wr(4'hC, 32'hA5030201);
    rd(4'hC, d); chk(d == 32'hA5030201, "R2 ratio readback", d, 32'hA5030201);
    wr(4'h0, 32'h00000ABC);
    rd(4'h0, d); chk(d == 32'h00000ABC, "R3 ctrl readback", d, 32'h00000ABC);
    wr(4'h0, 32'h0);
    rd(4'h4, d); chk(d == 0, "R11 unmapped read", d, 0);
    rd(4'h8, d); chk(d == 0, "R11 unmapped read", d, 0);
    expect_periods(1, 1, 1, 1, "R4 staging only");
  endtask

  task automatic t_apply;
    logic [31:0] d;
    wr(4'hC, 32'h09000203);
    apply(4'b0011);
    expect_periods(3, 2, 1, 1, "R5 selected cores");
    rd(4'h0, d); chk(d == 0, "R7 ctrl cleared", d, 0);
    repeat (7) @(negedge clk);
    expect_periods(3, 2, 1, 1, "R7 clear keeps ratios");
  endtask

  task automatic t_edge;
    wr(4'hC, 32'h09000201);
    wr(4'h0, (32'h1 << 20) | (32'h1 << 24));
    repeat (8) @(negedge clk);
    expect_periods(1, 2, 1, 1, "R6 first edge");
    wr(4'hC, 32'h09000202);
    wr(4'h0, (32'h1 << 20) | (32'h1 << 24));
    repeat (8) @(negedge clk);
    expect_periods(1, 2, 1, 1, "R6 held trigger");
    wr(4'h0, 32'h0);
    apply(4'b0001);
    expect_periods(2, 2, 1, 1, "R6 new edge");
  endtask

  task automatic t_sat;
    wr(4'hC, 32'h02020202);
    apply(4'b1100);
    expect_periods(2, 2, 2, 2, "R5 cores 2 3");
    wr(4'hC, 32'h3F000202);
    apply(4'b1100);
    expect_periods(2, 2, exp_ratio(0), exp_ratio(63), "R8 saturation");
  endtask

  task automatic glitch_scan(input int c, input int oldr, input int newr);
    int last = -1;
    int gap = 0;
    bit bad = 0;
    int bad_gap = 0;
    wr(4'h0, (32'h1 << (20 + c)) | (32'h1 << 24));
    wr(4'h0, 32'h0);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (core_tick[c]) begin
        if (last >= 0) begin
          gap = k - last;
          if (gap != oldr && gap != newr) begin bad = 1; bad_gap = gap; end
        end
        last = k;
      end
    end
    chk(!bad, "R10 clean switch gaps", bad_gap, newr);
    chk(gap == newr, "R10 final gap", gap, newr);
  endtask

  task automatic t_runt;
    wr(4'hC, 32'h3F000302);
    glitch_scan(1, 2, 3);
    wr(4'hC, 32'h3F000102);
    glitch_scan(1, 3, 1);
    wr(4'hC, 32'h3F000302);
    glitch_scan(1, 1, 3);
  endtask

  task automatic t_width;
    int hi = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (core_tick[3]) hi++;
    end
    chk(hi == 4, "R9 pulse count ratio 3", hi, 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_apply();
    t_edge();
    t_sat();
    t_runt();
    t_width();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule